// File: doc/BRIEF.md
# Prescaled interval timer channel

A single timer channel built around one up/down counter. The counter is clocked through an optional power-of-two prescaler. It either runs freely across its whole range or repeats over a programmable interval from zero to a top value. Each time it lands on one of three programmable compare values, a sticky status flag is raised. Wraps and compare hits are collected in a status register, which drives one level interrupt through a per-bit enable mask.

The surrounding logic presents the clock-control, interval, compare and enable values as steady inputs. The counter-control word is loaded through a write strobe, because one of its bits is a one-shot command. A clear strobe empties the status register. The bit reserved for an external event cause exists in the status register but is never set.

Top module: `ptmr_channel`

## Requirements
- R1: With clock control bit 0 low, a running counter takes one step on every clock edge.
- R2: With clock control bit 0 high and N in clock control bits [PRE_SEL_W:1], the running counter steps only on the edges where the low N+1 bits of a free-running count of edges since reset release are all ones. Edges are counted from 0, so the counter steps once every 2^(N+1) clocks.
- R3: Counter control bit 0 (stop) holds the count. The reset value of counter control has stop set.
- R4: Counter control bit 1 selects interval mode. Counting up in interval mode, a count at or above `interval` steps to 0, and the wrap sets status bit 0.
- R5: In free-running mode (bit 1 low), the count wraps between all ones and zero, and the wrap sets status bit N_MATCH+1 (bit 4).
- R6: Counter control bit 2 selects counting down. A down step from 0 reloads the top of the range: `interval` in interval mode, all ones otherwise. That step counts as a wrap, with the status bit of R4 or R5.
- R7: A step that lands on compare value k sets status bit k+1, but only while counter control bit 3 is high. The compare value must also not exceed the top of the range.
- R8: After reset the count is 0, the status register is 0 and the interrupt is low.
- R9: Writing counter control with bit 4 high zeroes the count on that edge, taking priority over a step. Bit 4 is not kept, so counting continues from 0 afterwards.
- R10: Status bits stay set until the clear strobe is given. A clear zeroes all bits, except that causes arriving on the same edge are still set. Status bit N_MATCH+2 (bit 5) is never set.
- R11: The interrupt is high exactly when some status bit and its enable bit are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_ctrl | input | PRE_SEL_W+1 | Bit 0 enables the prescaler; upper bits hold the prescale select N |
| cnt_ctrl_we | input | 1 | Load strobe for the counter-control word |
| cnt_ctrl_wd | input | 5 | Counter-control word: stop, interval, down, compare enable, zero command |
| interval | input | CNT_W | Top of the range in interval mode |
| match_val | input | N_MATCH x CNT_W | Compare values, entry k drives status bit k+1 |
| irq_en | input | N_MATCH+3 | Per-bit interrupt enable |
| status_clr | input | 1 | Clears the status register |
| count | output | CNT_W | Current count |
| status | output | N_MATCH+3 | Sticky status register |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the channel with an 8-bit counter, a 4-bit prescale select and three compare values. With the narrow counter, a free-running wrap in either direction takes only 256 steps, so random stimulus crosses both wrap directions many times. Prescale selects up to 2 keep stepping dense while still exercising the edge-count phase alignment. Intervals down to zero and compare values above the interval top are drawn on purpose, so the boundary and suppression cases come up repeatedly.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  // counter-control bits that stay loaded (MSB first: bit 3 .. bit 0)
  typedef struct packed {
    logic match_en;
    logic down;
    logic interval;
    logic stop;
  } run_ctrl_t;

  localparam int CC_W        = 5;
  localparam int CC_ZERO_BIT = 4;

  localparam run_ctrl_t RUN_CTRL_RESET = '{match_en: 1'b0, down: 1'b0,
                                           interval: 1'b0, stop: 1'b1};

  function automatic run_ctrl_t decode_ctrl(input logic [CC_W-1:0] wd);
    return run_ctrl_t'(wd[3:0]);
  endfunction

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = 1 << SEL_W;

  logic [PRE_W-1:0] phase_q;

  // N+1 low ones: a period of 2^(N+1) edges
  function automatic logic [PRE_W-1:0] phase_mask(input logic [SEL_W-1:0] n);
    return {PRE_W{1'b1}} >> ((PRE_W - 1) - int'(n));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + 1'b1;
  end

  assign tick = ~en | ((phase_q & phase_mask(sel)) == phase_mask(sel));

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             zero_cmd,
  input  logic             down,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] land,
  output logic             step_ev,
  output logic             wrap_ev
);
  logic wrap;

  // {wrap, next value} for one step from cur
  function automatic logic [CNT_W:0] step_fn(input logic [CNT_W-1:0] cur,
                                             input logic [CNT_W-1:0] lim,
                                             input logic             dn);
    if (dn) begin
      if (cur == '0) return {1'b1, lim};
      return {1'b0, cur - 1'b1};
    end
    if (cur >= lim) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, cur + 1'b1};
  endfunction

  assign {wrap, land} = step_fn(count, top, down);
  assign step_ev      = adv & ~zero_cmd;
  assign wrap_ev      = step_ev & wrap;

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (zero_cmd) count <= '0;
    else if (step_ev)  count <= land;
  end

endmodule

// File: rtl/ptmr_match.sv
module ptmr_match #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 3
) (
  input  logic                          step_ev,
  input  logic                          enable,
  input  logic [CNT_W-1:0]              land,
  input  logic [CNT_W-1:0]              top,
  input  logic [N_MATCH-1:0][CNT_W-1:0] match_val,
  output logic [N_MATCH-1:0]            hit
);
  for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
    assign hit[k] = enable & step_ev & (land == match_val[k]) & (match_val[k] <= top);
  end

endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
  import ptmr_pkg::*;
#(
  parameter  int CNT_W     = 16,
  parameter  int PRE_SEL_W = 4,
  parameter  int N_MATCH   = 3,
  localparam int ST_W      = N_MATCH + 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [PRE_SEL_W:0]            clk_ctrl,
  input  logic                          cnt_ctrl_we,
  input  logic [CC_W-1:0]               cnt_ctrl_wd,
  input  logic [CNT_W-1:0]              interval,
  input  logic [N_MATCH-1:0][CNT_W-1:0] match_val,
  input  logic [ST_W-1:0]               irq_en,
  input  logic                          status_clr,
  output logic [CNT_W-1:0]              count,
  output logic [ST_W-1:0]               status,
  output logic                          irq
);
  localparam int ST_IVL = 0;
  localparam int ST_OVF = N_MATCH + 1;
  localparam int ST_EVT = N_MATCH + 2;

  run_ctrl_t          ctrl_q;
  logic               run_stop, run_dn, run_int, run_men;
  logic               tick, adv, zero_cmd, step_ev, wrap_ev;
  logic [CNT_W-1:0]   top, land;
  logic [N_MATCH-1:0] hit;
  logic [ST_W-1:0]    cause, status_q;

  assign zero_cmd = cnt_ctrl_we & cnt_ctrl_wd[CC_ZERO_BIT];

  always_ff @(posedge clk) begin
    if (rst)              ctrl_q <= RUN_CTRL_RESET;
    else if (cnt_ctrl_we) ctrl_q <= decode_ctrl(cnt_ctrl_wd);
  end

  assign run_stop = ctrl_q.stop;
  assign run_dn   = ctrl_q.down;
  assign run_int  = ctrl_q.interval;
  assign run_men  = ctrl_q.match_en;

  assign top = run_int ? interval : {CNT_W{1'b1}};
  assign adv = tick & ~run_stop;

  ptmr_prescale #(.SEL_W(PRE_SEL_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .en   (clk_ctrl[0]),
    .sel  (clk_ctrl[PRE_SEL_W:1]),
    .tick (tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .zero_cmd (zero_cmd),
    .down     (run_dn),
    .top      (top),
    .count    (count),
    .land     (land),
    .step_ev  (step_ev),
    .wrap_ev  (wrap_ev)
  );

  ptmr_match #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_cmp (
    .step_ev   (step_ev),
    .enable    (run_men),
    .land      (land),
    .top       (top),
    .match_val (match_val),
    .hit       (hit)
  );

  always_comb begin
    cause                 = '0;
    cause[ST_IVL]         = wrap_ev & run_int;
    cause[N_MATCH:1]      = hit;
    cause[ST_OVF]         = wrap_ev & ~run_int;
    cause[ST_EVT]         = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_clr ? '0 : status_q) | cause;
  end

  assign status = status_q;
  assign irq    = |(status_q & irq_en);

endmodule

// File: rtl/ptmr_channel_chk.sv
module ptmr_channel_chk #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 3,
  parameter int ST_W    = N_MATCH + 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count,
  input logic [ST_W-1:0]  status,
  input logic [ST_W-1:0]  cause,
  input logic [CNT_W-1:0] top,
  input logic             run_stop,
  input logic             run_dn,
  input logic             run_int,
  input logic             run_men,
  input logic             adv,
  input logic             zero_cmd,
  input logic             wrap_ev,
  input logic             status_clr
);
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (run_stop && !zero_cmd) |=> $stable(count)); // R3

  AST_ZERO_CMD: assert property (@(posedge clk) disable iff (rst)
    zero_cmd |=> (count == '0)); // R9

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !zero_cmd && !run_dn && (count < top)) |=> (count == $past(count) + 1'b1)); // R4

  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (adv && !zero_cmd && run_dn && (count == '0)) |=> (count == $past(top))); // R6

  AST_IVL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wrap_ev && run_int) |=> status[0]); // R4

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wrap_ev && !run_int) |=> status[N_MATCH+1]); // R5

  AST_EVENT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !status[N_MATCH+2]); // R10

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (status_clr && (cause == '0)) |=> (status == '0)); // R10

  AST_MATCH_GATED: assert property (@(posedge clk) disable iff (rst)
    !run_men |=> ((status[N_MATCH:1] & ~$past(status[N_MATCH:1])) == '0)); // R7

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> ((count == '0) && (status == '0))); // R8

endmodule

bind ptmr_channel ptmr_channel_chk #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .count      (count),
  .status     (status),
  .cause      (cause),
  .top        (top),
  .run_stop   (run_stop),
  .run_dn     (run_dn),
  .run_int    (run_int),
  .run_men    (run_men),
  .adv        (adv),
  .zero_cmd   (zero_cmd),
  .wrap_ev    (wrap_ev),
  .status_clr (status_clr)
);

// File: tb/ptmr_channel_tb_top.sv
module ptmr_channel_tb_top;
  localparam int TW  = 8;
  localparam int SW  = 4;
  localparam int NM  = 3;
  localparam int STW = NM + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [SW:0]           clk_ctrl;
  logic                  we;
  logic [4:0]            wd;
  logic [TW-1:0]         ival;
  logic [NM-1:0][TW-1:0] mv;
  logic [STW-1:0]        ien;
  logic                  clr;
  logic [TW-1:0]         count;
  logic [STW-1:0]        status;
  logic                  irq;

  ptmr_channel #(.CNT_W(TW), .PRE_SEL_W(SW), .N_MATCH(NM)) dut_i (
    .clk(clk), .rst(rst), .clk_ctrl(clk_ctrl), .cnt_ctrl_we(we), .cnt_ctrl_wd(wd),
    .interval(ival), .match_val(mv), .irq_en(ien), .status_clr(clr),
    .count(count), .status(status), .irq(irq)
  );

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  // reference state, taken from the requirements
  logic [TW-1:0]  m_cnt;
  logic [STW-1:0] m_st;
  logic           m_stop, m_int, m_dn, m_men;
  int             ph;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] exp_top();
    return m_int ? ival : {TW{1'b1}};
  endfunction

  task automatic model_edge();
    logic [TW-1:0]  lim, nx;
    logic [STW-1:0] cause;
    logic           wrap, tick;
    int             mask;
    lim   = exp_top();
    mask  = (1 << (int'(clk_ctrl[SW:1]) + 1)) - 1;
    tick  = !clk_ctrl[0] || ((ph & mask) == mask);
    cause = '0;
    wrap  = 1'b0;
    nx    = m_cnt;
    if (we && wd[4]) nx = '0;
    else if (tick && !m_stop) begin
      if (m_dn) begin
        if (m_cnt == '0) begin nx = lim; wrap = 1'b1; end
        else nx = m_cnt - 1'b1;
      end else begin
        if (m_cnt >= lim) begin nx = '0; wrap = 1'b1; end
        else nx = m_cnt + 1'b1;
      end
      if (wrap) begin
        if (m_int) cause[0] = 1'b1;
        else       cause[NM+1] = 1'b1;
      end
      if (m_men)
        for (int k = 0; k < NM; k++)
          if (nx == mv[k] && mv[k] <= lim) cause[k+1] = 1'b1;
    end
    m_st  = (clr ? '0 : m_st) | cause;
    m_cnt = nx;
    if (we) begin
      m_stop = wd[0]; m_int = wd[1]; m_dn = wd[2]; m_men = wd[3];
    end
    ph++;
  endtask

  task automatic compare(string req);
    check(req, "count", int'(count), int'(m_cnt));
    check(req, "status", int'(status), int'(m_st));
    check("R11", "irq", int'(irq), int'(|(m_st & ien)));
  endtask

  task automatic run_cycle(string req);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic run_n(int n, string req);
    for (int i = 0; i < n; i++) run_cycle(req);
  endtask

  task automatic write_ctrl(logic [4:0] v, string req);
    we = 1'b1; wd = v;
    run_cycle(req);
    we = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(5_000_000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd48611));
    clk_ctrl = '0; we = 1'b0; wd = '0; ival = 8'd5;
    mv = '0; ien = '1; clr = 1'b0;
    repeat (3) @(negedge clk);
    m_cnt = '0; m_st = '0; m_stop = 1'b1; m_int = 1'b0; m_dn = 1'b0; m_men = 1'b0; ph = 0;
    check("R8", "count after reset", int'(count), 0);
    check("R8", "status after reset", int'(status), 0);
    check("R8", "irq after reset", int'(irq), 0);
    rst = 1'b0;

    // stopped by the reset value of counter control
    run_n(6, "R3");
    check("R3", "count held", int'(count), 0);

    // free running, no prescaler: one step per clock
    write_ctrl(5'h00, "R1");
    run_n(10, "R1");
    check("R1", "count after 11 edges", int'(count), 10);

    // stop mid-count
    write_ctrl(5'h01, "R3");
    run_n(5, "R3");

    // interval mode counting up, top 5
    ival = 8'd5;
    write_ctrl(5'h12, "R4");
    run_n(20, "R4");

    // clear strobe, then clears held while wraps keep arriving
    clr = 1'b1; run_cycle("R10"); clr = 1'b0;
    run_n(8, "R10");
    clr = 1'b1; run_n(8, "R10"); clr = 1'b0;

    // counting down in interval mode
    write_ctrl(5'h06, "R6");
    run_n(20, "R6");

    // compare hits, one value above the top
    mv[0] = 8'd2; mv[1] = 8'd3; mv[2] = 8'd9;
    clr = 1'b1; write_ctrl(5'h1a, "R7"); clr = 1'b0;
    run_n(20, "R7");
    check("R7", "compare above top never set", int'(status[3]), 0);
    clr = 1'b1; write_ctrl(5'h12, "R7"); clr = 1'b0;
    run_n(20, "R7");
    check("R7", "compare bits gated off", int'(status[3:1]), 0);

    // prescaler, N = 2 and N = 0
    clk_ctrl = 5'b0010_1;
    write_ctrl(5'h10, "R2");
    run_n(40, "R2");
    clk_ctrl = 5'b0000_1;
    run_n(12, "R2");
    clk_ctrl = '0;

    // free-running wrap both ways
    clr = 1'b1; write_ctrl(5'h10, "R5"); clr = 1'b0;
    run_n(300, "R5");
    write_ctrl(5'h14, "R5");
    run_n(60, "R6");

    // zero command while running
    write_ctrl(5'h00, "R9");
    run_n(30, "R9");
    write_ctrl(5'h10, "R9");
    check("R9", "count after zero command", int'(count), 0);
    run_n(5, "R9");
    check("R9", "counting resumes", int'(count), 5);

    // interrupt masking
    ien = '0; run_n(3, "R11");
    check("R11", "irq masked", int'(irq), 0);
    ien = 6'b010000; run_n(3, "R11");
    ien = 6'b100000; run_n(3, "R11");
    ien = '1;

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        we = 1'b1;
        wd = 5'($urandom_range(0, 31));
        wd[0] = ($urandom_range(0, 3) == 0);
      end else we = 1'b0;
      clr = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 63) == 0)
        clk_ctrl = {4'($urandom_range(0, 2)), 1'($urandom_range(0, 1))};
      if ($urandom_range(0, 127) == 0) ival = 8'($urandom_range(0, 40));
      if ($urandom_range(0, 63) == 0) mv[$urandom_range(0, NM-1)] = 8'($urandom_range(0, 40));
      if ($urandom_range(0, 63) == 0) ien = 6'($urandom_range(0, 63));
      run_cycle("R4 R5 R6 R7 R10");
    end
    we = 1'b0; clr = 1'b0;
    run_n(4, "R10");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule